// File: doc/BRIEF.md
# Microcontroller I/O Port Unit

This block is the port subsystem of a small 4-bit microcontroller core. The instruction decoder gives it an operation code, a port-select code, accumulator data and a bit index. It runs one of four operations each machine cycle, which here is one clock cycle: read a port, write a port latch, set one latch bit, or clear one latch bit. Port reads are combinational. The read value and its status flag are valid in the same cycle as the operation, so the core can capture them at the next edge.

The block has three port groups:

- **Two-pin digital input.** Pin 0 also serves as the counter clock source and as the source of interrupt request 0.
- **Four-bit comparator port.** It returns digital comparator outcomes. A settling counter tracks whether the shared reference level has had time to settle since the last latch write, and flags a read taken too early.
- **Two latched output ports.** They are 3 bits and 2 bits wide. Each port is driven as push-pull or open-drain according to a static option.

Top module: `ioport_unit`

## Requirements
- R1: Operation code 1 (read) with select 0 returns the synchronized input pins: pin 0 on bit 0 and pin 1 on bit 1, with bits 3:2 at 0. When the static reference option `p1_is_ref_i` is 1, bit 1 reads 0 whatever level pin 1 has.
- R2: Operation code 1 with select 1 returns `cmp_i` unchanged on bits 3:0.
- R3: Any write, set or clear (codes 2, 3, 4) that targets select 8 or 9 restarts a 3-cycle settling window. A select-1 read in any of the three cycles that follow raises `unsettled_o`. A select-1 read from the fourth cycle on, or at any time after reset with no write, leaves it low.
- R4: Operation code 2 with select 8 loads `acc_i[2:0]` into the port-8 latch. With select 9 it loads `acc_i[1:0]` into the port-9 latch. The new value is at the pins from the next clock edge.
- R5: Operation code 3 sets and code 4 clears the latch bit given by `bit_idx_i` on the port chosen by select 8 or 9. The other bits stay unchanged. An index at or above the port width changes nothing.
- R6: Reset clears both latches, so in push-pull mode all port-8 and port-9 pins are low.
- R7: With `open_drain_i` = 0, the pins follow the latches and every output enable is 1. With `open_drain_i` = 1, the pad data is 0 and each enable is the inverse of its latch bit.
- R8: `cnt_clk_o` follows synchronized pin 0 while `clk_mode_i[2:1]` = 01, and is 0 otherwise.
- R9: When `irq0_en_i` = 1, a rising edge on pin 0 gives a one-cycle `irq0_o` pulse that is high between the second and third clock edges after the change. When `irq0_en_i` = 0 there is no pulse.
- R10: `rd_data_o` and `unsettled_o` are 0 for any operation other than a select-0 or select-1 read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one machine cycle per edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation: 0 none, 1 read, 2 write, 3 bit set, 4 bit clear |
| sel_i | input | 4 | Port select code |
| acc_i | input | 4 | Accumulator data for writes |
| bit_idx_i | input | 2 | Bit index for set and clear |
| rd_data_o | output | 4 | Read result for the accumulator |
| unsettled_o | output | 1 | Comparator read taken inside the settling window |
| in_pins_i | input | 2 | Digital input pins |
| cmp_i | input | 4 | Comparator outcomes |
| p1_is_ref_i | input | 1 | Static option: pin 1 serves as reference input |
| clk_mode_i | input | 3 | Clock mode bits |
| irq0_en_i | input | 1 | Interrupt 0 enable flag |
| cnt_clk_o | output | 1 | Counter clock taken from pin 0 |
| irq0_o | output | 1 | Interrupt request 0 pulse |
| open_drain_i | input | 1 | Static option: open-drain drive |
| p8_o | output | 3 | Port 8 pad data |
| p8_oe_o | output | 3 | Port 8 output enables |
| p9_o | output | 2 | Port 9 pad data |
| p9_oe_o | output | 2 | Port 9 output enables |

## Verification
The latch operations are driven with alternating and all-ones accumulator values. Set and clear are each applied to a single bit on top of a known pattern. This separates a correct bit merge from an operation that overwrites the whole latch, and it catches a wrong bit order. Comparator reads are placed at every cycle distance from 1 to 5 after a write, which pins down the exact end of the settling window. Pin 1 is read with the reference option both on and off. Pin 0 is toggled with the interrupt enable and the clock-mode field each set and cleared, so every alternate function is shown to be gated by its own control.

// File: rtl/ioport_pkg.sv
package ioport_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_IN   = 3'd1,
    OP_OUT  = 3'd2,
    OP_SET  = 3'd3,
    OP_CLR  = 3'd4
  } port_op_e;

  parameter int SEL_W  = 4;
  parameter int ACC_W  = 4;
  parameter int BIT_W  = 2;
  parameter int SEL_IN = 0;
  parameter int SEL_CM = 1;
  parameter int SEL_P8 = 8;
  parameter int SEL_P9 = 9;
endpackage

// File: rtl/ioport_sync.sv
module ioport_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] sync_o,
  output logic         rise0_o
);
  logic [W-1:0] s1_q, s2_q;
  logic         s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pins_i;
      s2_q <= s1_q;
      s3_q <= s2_q[0];
    end
  end

  assign sync_o  = s2_q;
  assign rise0_o = s2_q[0] & ~s3_q;
endmodule

// File: rtl/ioport_settle.sv
module ioport_settle #(
  parameter int SETTLE_CYC = 3,
  localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (restart_i)     cnt_q <= CNT_W'(SETTLE_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ioport_latch.sv
module ioport_latch
  import ioport_pkg::*;
#(
  parameter int W   = 3,
  parameter int SEL = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [W-1:0]     acc_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic             open_drain_i,
  output logic [W-1:0]     pad_o,
  output logic [W-1:0]     oe_o,
  output logic             wr_o
);
  logic         hit;
  logic [W-1:0] lat_q, lat_d;

  assign hit  = (sel_i == SEL_W'(SEL));
  assign wr_o = hit && (op_i == OP_OUT || op_i == OP_SET || op_i == OP_CLR);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic sel_bit;
    assign sel_bit = (bit_idx_i == BIT_W'(i));
    always_comb begin
      lat_d[i] = lat_q[i];
      if (hit) begin
        case (op_i)
          OP_OUT:  lat_d[i] = acc_i[i];
          OP_SET:  if (sel_bit) lat_d[i] = 1'b1;
          OP_CLR:  if (sel_bit) lat_d[i] = 1'b0;
          default: lat_d[i] = lat_q[i];
        endcase
      end
    end
    // open-drain: pad low only, release when latch is 1
    assign pad_o[i] = open_drain_i ? 1'b0 : lat_q[i];
    assign oe_o[i]  = open_drain_i ? ~lat_q[i] : 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_q <= '0;
    else         lat_q <= lat_d;
  end
endmodule

// File: rtl/ioport_unit.sv
module ioport_unit
  import ioport_pkg::*;
#(
  parameter int SETTLE_CYC = 3,
  parameter int P8_W       = 3,
  parameter int P9_W       = 2,
  parameter int CMP_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  output logic [ACC_W-1:0] rd_data_o,
  output logic             unsettled_o,
  input  logic [1:0]       in_pins_i,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic             p1_is_ref_i,
  input  logic [2:0]       clk_mode_i,
  input  logic             irq0_en_i,
  output logic             cnt_clk_o,
  output logic             irq0_o,
  input  logic             open_drain_i,
  output logic [P8_W-1:0]  p8_o,
  output logic [P8_W-1:0]  p8_oe_o,
  output logic [P9_W-1:0]  p9_o,
  output logic [P9_W-1:0]  p9_oe_o
);
  logic [1:0] pins_s;
  logic       rise0, wr8, wr9, busy;

  ioport_sync #(.W(2)) u_sync (
    .clk_i, .rst_ni, .pins_i(in_pins_i), .sync_o(pins_s), .rise0_o(rise0)
  );

  ioport_latch #(.W(P8_W), .SEL(SEL_P8)) u_p8 (
    .clk_i, .rst_ni, .op_i, .sel_i, .acc_i(acc_i[P8_W-1:0]), .bit_idx_i,
    .open_drain_i, .pad_o(p8_o), .oe_o(p8_oe_o), .wr_o(wr8)
  );

  ioport_latch #(.W(P9_W), .SEL(SEL_P9)) u_p9 (
    .clk_i, .rst_ni, .op_i, .sel_i, .acc_i(acc_i[P9_W-1:0]), .bit_idx_i,
    .open_drain_i, .pad_o(p9_o), .oe_o(p9_oe_o), .wr_o(wr9)
  );

  ioport_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i, .rst_ni, .restart_i(wr8 | wr9), .busy_o(busy)
  );

  always_comb begin
    rd_data_o   = '0;
    unsettled_o = 1'b0;
    if (op_i == OP_IN) begin
      if (sel_i == SEL_W'(SEL_IN)) begin
        rd_data_o[0] = pins_s[0];
        rd_data_o[1] = pins_s[1] & ~p1_is_ref_i;
      end else if (sel_i == SEL_W'(SEL_CM)) begin
        rd_data_o   = ACC_W'(cmp_i);
        unsettled_o = busy;
      end
    end
  end

  assign cnt_clk_o = (clk_mode_i[2:1] == 2'b01) & pins_s[0];
  assign irq0_o    = irq0_en_i & rise0;
endmodule

// File: rtl/ioport_unit_chk.sv
module ioport_unit_chk
  import ioport_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic [SEL_W-1:0] sel_i,
  input logic [ACC_W-1:0] acc_i,
  input logic [ACC_W-1:0] rd_data_o,
  input logic             unsettled_o,
  input logic             irq0_en_i,
  input logic             irq0_o,
  input logic             open_drain_i,
  input logic [2:0]       p8_o,
  input logic [1:0]       p9_o
);
  logic wr_any, rd_cm;
  assign wr_any = (op_i == OP_OUT || op_i == OP_SET || op_i == OP_CLR) &&
                  (sel_i == SEL_W'(SEL_P8) || sel_i == SEL_W'(SEL_P9));
  assign rd_cm  = (op_i == OP_IN) && (sel_i == SEL_W'(SEL_CM));

  // R3
  settle_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |=> (rd_cm -> unsettled_o));

  // R4
  p8_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_OUT && sel_i == SEL_W'(SEL_P8) && !open_drain_i) |=>
      (open_drain_i || p8_o == $past(acc_i[2:0])));

  // R7
  od_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_drain_i |-> (p8_o == '0 && p9_o == '0));

  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq0_o |-> irq0_en_i);

  // R9
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq0_o && irq0_en_i) |=> !irq0_o);

  // R10
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != OP_IN) |-> (rd_data_o == '0 && !unsettled_o));
endmodule

bind ioport_unit ioport_unit_chk u_chk (
  .clk_i, .rst_ni, .op_i, .sel_i, .acc_i, .rd_data_o, .unsettled_o,
  .irq0_en_i, .irq0_o, .open_drain_i, .p8_o, .p9_o
);

// File: tb/ioport_unit_test.sv
module ioport_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [3:0] sel = 4'd0, acc = 4'd0, cmp = 4'd0;
  logic [1:0] bidx = 2'd0, pins = 2'd0;
  logic       p1ref = 1'b0, irq_en = 1'b0, od = 1'b0;
  logic [2:0] cmode = 3'd0;
  logic [3:0] rd;
  logic       uns, cclk, irq;
  logic [2:0] p8, p8oe;
  logic [1:0] p9, p9oe;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  ioport_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .sel_i(sel), .acc_i(acc),
    .bit_idx_i(bidx), .rd_data_o(rd), .unsettled_o(uns), .in_pins_i(pins),
    .cmp_i(cmp), .p1_is_ref_i(p1ref), .clk_mode_i(cmode), .irq0_en_i(irq_en),
    .cnt_clk_o(cclk), .irq0_o(irq), .open_drain_i(od),
    .p8_o(p8), .p8_oe_o(p8oe), .p9_o(p9), .p9_oe_o(p9oe)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // drive op at negedge, let it take effect at next posedge, return at following negedge
  task automatic do_op(logic [2:0] o, logic [3:0] s, logic [3:0] a, logic [1:0] b);
    op = o; sel = s; acc = a; bidx = b;
    @(posedge clk); @(negedge clk);
    op = 3'd0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic t_reset();
    chk("R6 p8 after reset", p8, 0);
    chk("R6 p9 after reset", p9, 0);
    chk("R7 p8 oe push-pull", p8oe, 7);
    op = 3'd1; sel = 4'd1; cmp = 4'hA; #1;
    chk("R3 unsettled after reset", uns, 0);
    chk("R2 cmp read", rd, 10);
    op = 3'd0; #1;
    chk("R10 idle read", rd, 0);
  endtask

  task automatic t_latch();
    do_op(3'd2, 4'd8, 4'b1101, 2'd0);
    chk("R4 p8 load", p8, 5);
    do_op(3'd2, 4'd9, 4'b1110, 2'd0);
    chk("R4 p9 load", p9, 2);
    chk("R4 p8 untouched", p8, 5);
    do_op(3'd3, 4'd8, 4'd0, 2'd1);
    chk("R5 p8 set bit1", p8, 7);
    do_op(3'd4, 4'd8, 4'd0, 2'd0);
    chk("R5 p8 clr bit0", p8, 6);
    do_op(3'd3, 4'd9, 4'd0, 2'd0);
    chk("R5 p9 set bit0", p9, 3);
    do_op(3'd4, 4'd9, 4'd0, 2'd2);
    chk("R5 p9 out-of-range clr", p9, 3);
    do_op(3'd4, 4'd8, 4'd0, 2'd3);
    chk("R5 p8 out-of-range clr", p8, 6);
    do_op(3'd2, 4'd5, 4'hF, 2'd0);
    chk("R4 other select no write", p8, 6);
  endtask

  task automatic t_drive();
    od = 1'b1; #1;
    chk("R7 od p8 data", p8, 0);
    chk("R7 od p8 oe", p8oe, 1);
    chk("R7 od p9 oe", p9oe, 0);
    od = 1'b0; #1;
    chk("R7 pp p9 oe", p9oe, 3);
    chk("R7 pp p8 data", p8, 6);
  endtask

  task automatic t_settle();
    do_op(3'd2, 4'd8, 4'd0, 2'd0);
    for (int k = 1; k <= 5; k++) begin
      op = 3'd1; sel = 4'd1; cmp = 4'h5; #1;
      chk($sformatf("R3 unsettled at distance %0d", k), uns, (k <= 3) ? 1 : 0);
      chk("R2 cmp value", rd, 5);
      @(posedge clk); @(negedge clk);
    end
    op = 3'd0;
    do_op(3'd3, 4'd9, 4'd0, 2'd1);
    idle(2);
    op = 3'd1; sel = 4'd1; #1;
    chk("R3 set op restarts window", uns, 1);
    sel = 4'd0; #1;
    chk("R10 no flag on port0 read", uns, 0);
    op = 3'd0;
  endtask

  task automatic t_inputs();
    pins = 2'b11; p1ref = 1'b0; idle(3);
    op = 3'd1; sel = 4'd0; #1;
    chk("R1 both pins", rd, 3);
    p1ref = 1'b1; #1;
    chk("R1 pin1 as reference", rd, 1);
    pins = 2'b10; p1ref = 1'b0; op = 3'd0; idle(3);
    op = 3'd1; #1;
    chk("R1 pin1 only", rd, 2);
    op = 3'd2; sel = 4'd0; #1;
    chk("R10 non-read op", rd, 0);
    op = 3'd0;
  endtask

  task automatic t_alt();
    pins = 2'b00; cmode = 3'b010; irq_en = 1'b1; idle(3);
    chk("R8 cnt clk low", cclk, 0);
    pins = 2'b01;
    @(posedge clk); @(negedge clk);
    chk("R9 no irq after one edge", irq, 0);
    @(posedge clk); @(negedge clk);
    chk("R9 irq pulse", irq, 1);
    chk("R8 cnt clk follows pin", cclk, 1);
    @(posedge clk); @(negedge clk);
    chk("R9 irq single cycle", irq, 0);
    cmode = 3'b100; #1;
    chk("R8 other mode gated", cclk, 0);
    cmode = 3'b011; #1;
    chk("R8 mode bit0 ignored", cclk, 1);
    irq_en = 1'b0; pins = 2'b00; idle(3);
    pins = 2'b01; idle(2);
    chk("R9 irq disabled", irq, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_latch();
    t_drive();
    t_settle();
    t_inputs();
    t_alt();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule